// File: doc/BRIEF.md
# Per-Thread Hardware Return Stack

This block keeps a small hardware stack for each of several threads that share one execution pipeline. A call saves the caller's zero and carry flags together with the return address. A return takes that entry back and hands the program counter to the fetch logic, and it restores the flags only when the return asks for them. The same stack also serves plain data pushes and pops. A delayed call saves a return address that skips the calling thread's instructions that are already in flight, and the pipeline reports how many there are.

Each thread presents one operation code per cycle. All threads are served in the same cycle without interfering with each other. Results appear one cycle after the operation on registered outputs. The stack does not track how full it is. Its write pointer wraps modulo the depth, so an overflow replaces the oldest entry and an underflow reads whatever the slot below the pointer holds. Neither case is reported as an error.

Top module: `thread_return_stack`

## Requirements
- R1: After a synchronous active-low reset, every output is zero, every stack slot holds zero and every write pointer is zero. A pop issued right after reset therefore returns zero.
- R2: Operation code 1 (call) stores a 32-bit entry with Z at bit 17, C at bit 16, the value cur_pc+1 (modulo 2^16) in bits [15:0] and zeros in bits [31:18]. Popping that entry with code 5 returns exactly this word.
- R3: Operation code 2 (delayed call) stores the same layout as R2, but bits [15:0] hold cur_pc+1+pipe_n (modulo 2^16). pipe_n is the thread's 2-bit in-flight count.
- R4: Operation code 3 (return) removes the top entry. One cycle later it raises pc_load for exactly that cycle, with pc_out equal to entry bits [15:0].
- R5: On a return, z_we follows ret_wz and c_we follows ret_wc. z_val and c_val carry entry bits 17 and 16. A return without qualifiers raises neither write enable.
- R6: Operation code 4 (push) stores the 32-bit push_data. Operation code 5 (pop) removes the top entry, and one cycle later it raises pop_valid with pop_data equal to that entry. Entries come back last-in, first-out.
- R7: With a depth of 4, the fifth push without a pop overwrites the oldest slot. After pushes A, B, C, D, E, five pops return E, D, C, B, E.
- R8: A pop or return on a stack that has been emptied reads the slot just below the write pointer, modulo the depth, and moves the pointer down again. No error is raised.
- R9: Each thread's operation uses only its own stack and outputs. Different operations on different threads in the same cycle give the same results as if each had been issued alone.
- R10: Operation code 0 and the unused codes 6 and 7 leave the stack unchanged. In the cycle after such a code, pc_load, pop_valid, z_we and c_we are low and the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 12 | 3-bit operation per thread; thread t uses bits [3t+2:3t] |
| cur_pc | input | 64 | 16-bit address of the calling instruction per thread |
| pipe_n | input | 8 | 2-bit count of the thread's own instructions in flight |
| flag_z | input | 4 | Current Z flag per thread |
| flag_c | input | 4 | Current C flag per thread |
| push_data | input | 128 | 32-bit data word per thread for push |
| ret_wz | input | 4 | Return restores Z, per thread |
| ret_wc | input | 4 | Return restores C, per thread |
| pc_load | output | 4 | Load program counter, per thread |
| pc_out | output | 64 | 16-bit return address per thread |
| z_we | output | 4 | Write Z flag, per thread |
| z_val | output | 4 | Restored Z value, per thread |
| c_we | output | 4 | Write C flag, per thread |
| c_val | output | 4 | Restored C value, per thread |
| pop_valid | output | 4 | Popped data valid, per thread |
| pop_data | output | 128 | 32-bit popped word per thread |

## Verification
Two kinds of work can land in the same cycle: a stack-changing operation on one thread and a different one on another thread. Examples are a delayed call on one thread while another returns with flag restore, or a push beside a pop. The sweep sets every thread's operation, address, in-flight count, flags and qualifiers from separate arithmetic patterns in each cycle, so all pairings occur repeatedly, including wrap past full and empty. Each thread's outputs are compared every cycle against a per-thread model of slots and pointer kept in the bench. A result leaking between threads, or a pointer moved by another thread's operation, shows up as a mismatch.

// File: rtl/rstk_pkg.sv
// Package rstk_pkg
// Shared operation codes and entry layout helpers for the per-thread
// return stack. Assumes the program counter is narrower than the entry,
// so that the two flag bits fit directly above it.
package rstk_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_CALL  = 3'd1,
        OP_CALLD = 3'd2,
        OP_RET   = 3'd3,
        OP_PUSH  = 3'd4,
        OP_POP   = 3'd5
    } rstk_op_e;

    localparam int OP_W = 3;

    // True for every code that writes a new entry.
    function automatic logic op_is_push(input logic [OP_W-1:0] op);
        return (op == OP_CALL) || (op == OP_CALLD) || (op == OP_PUSH);
    endfunction

    // True for every code that removes the top entry.
    function automatic logic op_is_pop(input logic [OP_W-1:0] op);
        return (op == OP_RET) || (op == OP_POP);
    endfunction

endpackage

// File: rtl/rstk_retaddr.sv
// Module rstk_retaddr
// Computes the return address saved by a call: the next address, moved
// further past the thread's own in-flight instructions when the call is
// delayed. Pure combinational; wraps modulo 2^PC_W.
module rstk_retaddr #(
    parameter int PC_W   = 16,
    parameter int PIPE_W = 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic              delayed,
    input  logic [PIPE_W-1:0] inflight,
    output logic [PC_W-1:0]   ret_addr
);

    logic [PC_W-1:0] skip;

    // Extra distance for a delayed call, zero otherwise.
    always_comb begin
        skip = delayed ? PC_W'(inflight) : '0;
    end

    // Next address plus the skip, wrapping.
    always_comb begin
        ret_addr = pc + PC_W'(1) + skip;
    end

endmodule

// File: rtl/rstk_lane.sv
// Module rstk_lane
// One thread's stack: DEPTH slots, a wrapping write pointer and the
// registered response. Assumes DEPTH is a power of two so that the
// pointer wraps by natural overflow, and that a single code per cycle
// is presented, so push and pop can never coincide.
module rstk_lane
    import rstk_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    parameter int PC_W   = 16,
    parameter int PIPE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op,
    input  logic [PC_W-1:0]   pc,
    input  logic [PIPE_W-1:0] inflight,
    input  logic              z_in,
    input  logic              c_in,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wz,
    input  logic              wc,
    output logic              rsp_pc_load,
    output logic [PC_W-1:0]   rsp_pc,
    output logic              rsp_z_we,
    output logic              rsp_z,
    output logic              rsp_c_we,
    output logic              rsp_c,
    output logic              rsp_pop_valid,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int C_POS = PC_W;
    localparam int Z_POS = PC_W + 1;

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  top_ptr;
    logic [PC_W-1:0]   ret_addr;
    logic [DATA_W-1:0] call_word;
    logic [DATA_W-1:0] new_word;
    logic [DATA_W-1:0] top_word;
    logic              do_push;
    logic              do_pop;

    u_addr_unused_guard : assert final (Z_POS < DATA_W);

    rstk_retaddr #(
        .PC_W   (PC_W),
        .PIPE_W (PIPE_W)
    ) u_retaddr (
        .pc       (pc),
        .delayed  (op == OP_CALLD),
        .inflight (inflight),
        .ret_addr (ret_addr)
    );

    // Decode the operation class.
    always_comb begin
        do_push = op_is_push(op);
        do_pop  = op_is_pop(op);
    end

    // Build the call entry: flags above the return address, rest zero.
    always_comb begin
        call_word                = '0;
        call_word[PC_W-1:0]      = ret_addr;
        call_word[C_POS]         = c_in;
        call_word[Z_POS]         = z_in;
    end

    // Select what a push writes.
    always_comb begin
        new_word = (op == OP_PUSH) ? wdata : call_word;
    end

    // Top of stack sits just below the write pointer.
    always_comb begin
        top_ptr  = wr_ptr - PTR_W'(1);
        top_word = slots[top_ptr];
    end

    // Write pointer moves up on push, down on pop, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (do_push) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end else if (do_pop) begin
            wr_ptr <= top_ptr;
        end
    end

    // Slot storage: a push writes the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                slots[s] <= '0;
            end
        end else if (do_push) begin
            slots[wr_ptr] <= new_word;
        end
    end

    // Registered response for returns and pops, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_pc_load   <= 1'b0;
            rsp_pc        <= '0;
            rsp_z_we      <= 1'b0;
            rsp_z         <= 1'b0;
            rsp_c_we      <= 1'b0;
            rsp_c         <= 1'b0;
            rsp_pop_valid <= 1'b0;
            rsp_data      <= '0;
        end else begin
            rsp_pc_load   <= (op == OP_RET);
            rsp_pc        <= (op == OP_RET) ? top_word[PC_W-1:0] : '0;
            rsp_z_we      <= (op == OP_RET) && wz;
            rsp_z         <= (op == OP_RET) && top_word[Z_POS];
            rsp_c_we      <= (op == OP_RET) && wc;
            rsp_c         <= (op == OP_RET) && top_word[C_POS];
            rsp_pop_valid <= (op == OP_POP);
            rsp_data      <= (op == OP_POP) ? top_word : '0;
        end
    end

    // A program-counter load only follows a return.
    p_pcload_after_ret_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pc_load |-> ($past(op) == OP_RET));

    // Flag write enables need a return carrying the matching qualifier.
    p_zwe_needs_qual_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_z_we |-> (($past(op) == OP_RET) && $past(wz)));

    p_cwe_needs_qual_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_c_we |-> (($past(op) == OP_RET) && $past(wc)));

    // Push advances the pointer by one, wrapping past full.
    p_push_advances_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> (wr_ptr == PTR_W'($past(wr_ptr) + PTR_W'(1))));

    // Pop retreats the pointer by one, wrapping past empty.
    p_pop_retreats_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> (wr_ptr == PTR_W'($past(wr_ptr) - PTR_W'(1))));

    // Idle and unused codes leave the pointer alone and raise nothing.
    p_idle_holds_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!do_push && !do_pop) |=> ($stable(wr_ptr) && !rsp_pc_load && !rsp_pop_valid));

endmodule

// File: rtl/thread_return_stack.sv
// Module thread_return_stack
// Top level: one independent stack lane per thread, with all per-thread
// signals carried on flat vectors (thread t in slice t). Assumes the
// surrounding pipeline issues at most one code per thread per cycle.
module thread_return_stack
    import rstk_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int DEPTH   = 4,
    parameter int DATA_W  = 32,
    parameter int PC_W    = 16,
    parameter int PIPE_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [THREADS*OP_W-1:0]   op_code,
    input  logic [THREADS*PC_W-1:0]   cur_pc,
    input  logic [THREADS*PIPE_W-1:0] pipe_n,
    input  logic [THREADS-1:0]        flag_z,
    input  logic [THREADS-1:0]        flag_c,
    input  logic [THREADS*DATA_W-1:0] push_data,
    input  logic [THREADS-1:0]        ret_wz,
    input  logic [THREADS-1:0]        ret_wc,
    output logic [THREADS-1:0]        pc_load,
    output logic [THREADS*PC_W-1:0]   pc_out,
    output logic [THREADS-1:0]        z_we,
    output logic [THREADS-1:0]        z_val,
    output logic [THREADS-1:0]        c_we,
    output logic [THREADS-1:0]        c_val,
    output logic [THREADS-1:0]        pop_valid,
    output logic [THREADS*DATA_W-1:0] pop_data
);

    // One lane per thread; no shared state between lanes (R9).
    for (genvar t = 0; t < THREADS; t++) begin : g_lane
        rstk_lane #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .PC_W   (PC_W),
            .PIPE_W (PIPE_W)
        ) u_lane (
            .clk           (clk),
            .rst_n         (rst_n),
            .op            (op_code[t*OP_W +: OP_W]),
            .pc            (cur_pc[t*PC_W +: PC_W]),
            .inflight      (pipe_n[t*PIPE_W +: PIPE_W]),
            .z_in          (flag_z[t]),
            .c_in          (flag_c[t]),
            .wdata         (push_data[t*DATA_W +: DATA_W]),
            .wz            (ret_wz[t]),
            .wc            (ret_wc[t]),
            .rsp_pc_load   (pc_load[t]),
            .rsp_pc        (pc_out[t*PC_W +: PC_W]),
            .rsp_z_we      (z_we[t]),
            .rsp_z         (z_val[t]),
            .rsp_c_we      (c_we[t]),
            .rsp_c         (c_val[t]),
            .rsp_pop_valid (pop_valid[t]),
            .rsp_data      (pop_data[t*DATA_W +: DATA_W])
        );
    end

endmodule

// File: tb/thread_return_stack_tb.sv
`timescale 1ns/1ps
module thread_return_stack_tb;

    localparam int T = 4;
    localparam int D = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [T*3-1:0]  op_code = '0;
    logic [T*16-1:0] cur_pc = '0;
    logic [T*2-1:0]  pipe_n = '0;
    logic [T-1:0]    flag_z = '0;
    logic [T-1:0]    flag_c = '0;
    logic [T*32-1:0] push_data = '0;
    logic [T-1:0]    ret_wz = '0;
    logic [T-1:0]    ret_wc = '0;
    logic [T-1:0]    pc_load;
    logic [T*16-1:0] pc_out;
    logic [T-1:0]    z_we, z_val, c_we, c_val, pop_valid;
    logic [T*32-1:0] pop_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_slot [T][D];
    int          m_ptr  [T];
    logic [53:0] exp_v  [T];
    string       tag_v  [T];

    always #2.5 clk = ~clk;

    thread_return_stack u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .cur_pc(cur_pc),
        .pipe_n(pipe_n), .flag_z(flag_z), .flag_c(flag_c),
        .push_data(push_data), .ret_wz(ret_wz), .ret_wc(ret_wc),
        .pc_load(pc_load), .pc_out(pc_out), .z_we(z_we), .z_val(z_val),
        .c_we(c_we), .c_val(c_val), .pop_valid(pop_valid), .pop_data(pop_data)
    );

    function automatic logic [53:0] observed(input int t);
        return {pc_load[t], pc_out[t*16 +: 16], z_we[t], z_val[t], c_we[t],
                c_val[t], pop_valid[t], pop_data[t*32 +: 32]};
    endfunction

    task automatic check(input string tag, input logic [53:0] act, input logic [53:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Set one thread's stimulus.
    task automatic set_lane(input int t, input logic [2:0] op, input logic [15:0] pc,
                            input logic [1:0] n, input logic z, input logic c,
                            input logic [31:0] d, input logic wz, input logic wc);
        op_code[t*3 +: 3]    = op;
        cur_pc[t*16 +: 16]   = pc;
        pipe_n[t*2 +: 2]     = n;
        flag_z[t]            = z;
        flag_c[t]            = c;
        push_data[t*32 +: 32]= d;
        ret_wz[t]            = wz;
        ret_wc[t]            = wc;
    endtask

    // Model the stimulus now on the inputs, clock once, compare all lanes.
    task automatic step(input string tag);
        for (int t = 0; t < T; t++) begin
            logic [2:0]  op = op_code[t*3 +: 3];
            logic [15:0] pc = cur_pc[t*16 +: 16];
            int          rp = (m_ptr[t] + D - 1) % D;
            logic [31:0] top = m_slot[t][rp];
            exp_v[t] = '0;
            tag_v[t] = tag;
            case (op)
                3'd1: begin
                    m_slot[t][m_ptr[t]] = {14'd0, flag_z[t], flag_c[t], 16'(pc + 16'd1)};
                    m_ptr[t] = (m_ptr[t] + 1) % D;
                end
                3'd2: begin
                    m_slot[t][m_ptr[t]] = {14'd0, flag_z[t], flag_c[t],
                                           16'(pc + 16'd1 + 16'(pipe_n[t*2 +: 2]))};
                    m_ptr[t] = (m_ptr[t] + 1) % D;
                end
                3'd3: begin
                    exp_v[t] = {1'b1, top[15:0], ret_wz[t], top[17], ret_wc[t],
                                top[16], 1'b0, 32'd0};
                    m_ptr[t] = rp;
                end
                3'd4: begin
                    m_slot[t][m_ptr[t]] = push_data[t*32 +: 32];
                    m_ptr[t] = (m_ptr[t] + 1) % D;
                end
                3'd5: begin
                    exp_v[t] = {1'b0, 16'd0, 4'd0, 1'b1, top};
                    m_ptr[t] = rp;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < T; t++) begin
            check($sformatf("%s thread %0d", tag_v[t], t), observed(t), exp_v[t]);
        end
        for (int t = 0; t < T; t++) set_lane(t, 3'd0, 16'd0, 2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < T; t++) begin
            m_ptr[t] = 0;
            for (int s = 0; s < D; s++) m_slot[t][s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs idle after reset, pops return zero.
        for (int t = 0; t < T; t++) check("R1 reset outputs", observed(t), 54'd0);
        for (int t = 0; t < T; t++) set_lane(t, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        step("R1 pop after reset");

        // R2: plain call entry layout, read back by pop.
        set_lane(1, 3'd1, 16'h1234, 2'd3, 1'b1, 1'b0, 0, 0, 0);
        step("R2 call");
        set_lane(1, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        step("R2 call entry");

        // R3: delayed call wraps past 16 bits.
        set_lane(2, 3'd2, 16'hFFFE, 2'd3, 1'b0, 1'b1, 0, 0, 0);
        step("R3 delayed call");
        set_lane(2, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        step("R3 delayed entry");

        // R4 and R5: return with each qualifier combination.
        for (int q = 0; q < 4; q++) begin
            set_lane(0, 3'd1, 16'(16'h0200 + q), 2'd0, q[0], ~q[0], 0, 0, 0);
            step("R2 call before return");
            set_lane(0, 3'd3, 0, 0, 0, 0, 0, q[0], q[1]);
            step("R4/R5 return flags");
        end

        // R6 and R7: five pushes then five pops on thread 3.
        for (int k = 0; k < 5; k++) begin
            set_lane(3, 3'd4, 0, 0, 0, 0, 32'hA0A0_0000 + k, 0, 0);
            step("R6 push");
        end
        for (int k = 0; k < 5; k++) begin
            set_lane(3, 3'd5, 0, 0, 0, 0, 0, 0, 0);
            step("R7 wrap pop");
        end

        // R8: underflow on thread 1 after it was emptied.
        set_lane(1, 3'd4, 0, 0, 0, 0, 32'h5555_AAAA, 0, 0);
        step("R6 push");
        set_lane(1, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        step("R6 pop");
        set_lane(1, 3'd3, 0, 0, 0, 0, 0, 1, 1);
        step("R8 underflow return");
        set_lane(1, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        step("R8 underflow pop");

        // R10: unused codes 6 and 7 change nothing; a pop then shows the top.
        set_lane(0, 3'd6, 16'h7777, 2'd1, 1, 1, 32'hDEAD_BEEF, 1, 1);
        set_lane(2, 3'd7, 16'h8888, 2'd2, 1, 1, 32'hFEED_F00D, 1, 1);
        step("R10 unused code");
        set_lane(0, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        set_lane(2, 3'd5, 0, 0, 0, 0, 0, 0, 0);
        step("R10 stack untouched");

        // R9: concurrent sweep, every lane busy with its own pattern.
        for (int i = 0; i < 600; i++) begin
            for (int t = 0; t < T; t++) begin
                int          sel = (i * 3 + t * 5 + i / 7) % 8;
                logic [15:0] pc  = 16'(i * 4099 + t * 77 + 16'hFFF0);
                logic [31:0] d   = 32'(i) * 32'h9E37_79B1 ^ 32'(t);
                set_lane(t, 3'(sel), pc, 2'((i + t) % 4), 1'(i ^ t), 1'(i >> 1),
                         d, 1'(i >> 2), 1'((i >> 3) ^ t));
            end
            step("R9 concurrent sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule